// File: doc/BRIEF.md
# Stack Frame Call/Return Sequencer

This block carries out procedure linkage for a processor whose operands live in memory. It owns the stack pointer and the base pointer and reaches a byte-addressed, 256-entry data memory through one synchronous port with a read latency of one cycle. Each command is a whole linkage step:
- push: places a literal, or a byte read from a memory operand, on the stack.
- call: stores the return address and redirects the program counter.
- salloc: builds the callee frame in one command.
- ret: tears the frame down and returns in one command.
- sdealloc: discards the caller's arguments.

The stack grows downward, one byte per element, and the stack pointer always addresses the newest element. A push lowers the stack pointer by one and then writes at the new address. A pop reads at the stack pointer and then raises it by one. Pointer arithmetic wraps modulo 256, and a flag reports any wrap that happened during the last command.

Commands arrive on a valid/ready stream. The unit takes a command only while idle, when `cmd_ready` is high. A producer that holds `cmd_valid` while the unit is busy is simply stalled: the command fields must stay stable until the accepting edge, and nothing is lost or taken twice. There is no back-pressure on the outputs. `done` and `pc_valid` are one-cycle pulses that the consumer must take when they occur.

Top module: `stack_frame_seq`

## Requirements
- R1: After reset, `sp` and `bp` are 8'hFF, `cmd_ready` is 1, and `done`, `pc_valid` and `err_wrap` are 0.
- R2: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 from the next cycle until `done` rises. A command held valid during that time is taken exactly once, after `done`.
- R3: Push with `cmd_op`=0 and `cmd_imm`=1 writes `cmd_arg` to address `sp`-1 and leaves `sp` lowered by one. `done` is high in the cycle after the 1st edge following acceptance.
- R4: Push with `cmd_op`=0 and `cmd_imm`=0 reads the memory byte at address `cmd_arg`, writes it to `sp`-1 and lowers `sp` by one. `done` is high after the 2nd edge following acceptance.
- R5: Call (`cmd_op`=1) writes `cmd_link` (the return address) to `sp`-1 and lowers `sp` by one. With `done`, after the 1st edge, `pc_valid` is 1 and `pc_value` equals `cmd_arg`.
- R6: Salloc (`cmd_op`=2, byte count `cmd_arg`) works in three steps. It stores the old `bp` at `sp`-1. It then sets `bp` to that address. Finally it sets `sp` to that address minus the byte count. `done` is high after the 2nd edge.
- R7: Ret (`cmd_op`=3) works in three steps. It sets `sp` to `bp`. It loads `bp` from the byte at that address. It loads `pc_value` from the byte one above that address. `sp` ends two above the old `bp`. `done` and `pc_valid` are high after the 5th edge.
- R8: Sdealloc (`cmd_op`=4, byte count `cmd_arg`) raises `sp` by the byte count, leaves `bp` alone, and makes no memory access. `done` is high after the 1st edge.
- R9: `done` is never high for two cycles in a row. `pc_valid` is high only together with `done` of a call or a ret.
- R10: `sp` arithmetic wraps modulo 256. At `done`, `err_wrap` is 1 exactly when some change of `sp` during that command crossed between 8'h00 and 8'hFF. `err_wrap` returns to 0 when the next command is taken.
- R11: The codes 5, 6 and 7 of `cmd_op` complete with `done` after the 1st edge. They leave `sp`, `bp` and memory unchanged and raise no `pc_valid`.
- R12: `mem_we` is 1 only with `mem_en`. The port makes at most one access per cycle and none while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_op | input | 3 | 0 push, 1 call, 2 salloc, 3 ret, 4 sdealloc, 5-7 unused |
| cmd_imm | input | 1 | Push source: 1 literal in `cmd_arg`, 0 memory byte at address `cmd_arg` |
| cmd_arg | input | 8 | Literal, operand address, byte count or call target |
| cmd_link | input | 8 | Return address stored by call |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read access |
| done | output | 1 | One-cycle pulse: the command has finished |
| pc_valid | output | 1 | One-cycle pulse: `pc_value` holds a new program counter |
| pc_value | output | 8 | Program counter from the last call or ret |
| sp | output | 8 | Stack pointer |
| bp | output | 8 | Base pointer |
| err_wrap | output | 1 | The last command wrapped the stack pointer |

## Verification
The hardest case to reach from the ports is a wrap on the final pop of a ret, where the return address sits at 8'hFF. To get there, the stimulus first wraps the stack pointer to 8'h00 with an sdealloc. It then pushes a literal that lands at 8'hFF, and builds a frame directly below it with salloc, so that the ret's last increment carries past the top. A second hard case is a command held valid across a multi-cycle salloc. The stimulus keeps the next push on the stream during the whole busy window and checks that it lands exactly once, after `done`.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  typedef enum logic [2:0] {
    OP_PUSH     = 3'd0,
    OP_CALL     = 3'd1,
    OP_SALLOC   = 3'd2,
    OP_RET      = 3'd3,
    OP_SDEALLOC = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SP_HOLD,
    SP_DEC1,
    SP_INC1,
    SP_SUBN,
    SP_ADDN,
    SP_FROM_BP
  } sp_op_e;

  typedef enum logic [1:0] {
    BP_HOLD,
    BP_FROM_SP,
    BP_LOAD
  } bp_op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ONE,
    ST_PUSH_RD,
    ST_PUSH_WR,
    ST_SAL_SAVE,
    ST_SAL_ANCH,
    ST_RET_UNW,
    ST_RET_RDBP,
    ST_RET_LDBP,
    ST_RET_RDPC,
    ST_RET_LDPC
  } state_e;

endpackage

// File: rtl/sfs_ptr_regs.sv
module sfs_ptr_regs
  import sfs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_op_e        sp_op,
  input  bp_op_e        bp_op,
  input  logic [AW-1:0] amount,
  input  logic [AW-1:0] load_val,
  input  logic          clr_err,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] bp,
  output logic          err
);

  localparam logic [AW:0] ONE_X = {{AW{1'b0}}, 1'b1};

  logic [AW:0]   sp_ext;
  logic [AW:0]   amt_ext;
  logic [AW-1:0] sp_nx;
  logic          wrap;

  assign amt_ext = {1'b0, amount};

  always_comb begin
    case (sp_op)
      SP_DEC1:    sp_ext = {1'b0, sp} - ONE_X;
      SP_INC1:    sp_ext = {1'b0, sp} + ONE_X;
      SP_SUBN:    sp_ext = {1'b0, sp} - amt_ext;
      SP_ADDN:    sp_ext = {1'b0, sp} + amt_ext;
      SP_FROM_BP: sp_ext = {1'b0, bp};
      default:    sp_ext = {1'b0, sp};
    endcase
  end

  assign sp_nx = sp_ext[AW-1:0];
  assign wrap  = sp_ext[AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= '1;
      bp  <= '1;
      err <= 1'b0;
    end else begin
      sp <= sp_nx;
      case (bp_op)
        BP_FROM_SP: bp <= sp;
        BP_LOAD:    bp <= load_val;
        default:    bp <= bp;
      endcase
      if (clr_err)   err <= 1'b0;
      else if (wrap) err <= 1'b1;
    end
  end

  // R11: with no step requested the stack pointer keeps its value
  p_sp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_op == SP_HOLD) |=> $stable(sp));

  // R6: base pointer only moves on a requested step
  p_bp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_op == BP_HOLD) |=> $stable(bp));

  // R10: a new command starts with a clear wrap flag
  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err);

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_imm,
  input  logic [AW-1:0] cmd_arg,
  input  logic [AW-1:0] cmd_link,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] bp,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  output sp_op_e        sp_op,
  output bp_op_e        bp_op,
  output logic [AW-1:0] amount,
  output logic          accept,
  output logic          done,
  output logic          pc_valid,
  output logic [AW-1:0] pc_value
);

  state_e        st_q, st_nx;
  logic [2:0]    op_q;
  logic          imm_q;
  logic [AW-1:0] arg_q;
  logic [AW-1:0] link_q;
  logic [AW-1:0] sp_m1;
  logic          fin;
  logic          pc_ld;
  logic [AW-1:0] pc_nx;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign sp_m1     = sp - {{(AW-1){1'b0}}, 1'b1};
  assign amount    = arg_q;

  always_comb begin
    st_nx     = st_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    sp_op     = SP_HOLD;
    bp_op     = BP_HOLD;
    fin       = 1'b0;
    pc_ld     = 1'b0;
    pc_nx     = arg_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          case (op_e'(cmd_op))
            OP_PUSH:   st_nx = cmd_imm ? ST_ONE : ST_PUSH_RD;
            OP_SALLOC: st_nx = ST_SAL_SAVE;
            OP_RET:    st_nx = ST_RET_UNW;
            default:   st_nx = ST_ONE;
          endcase
        end
      end
      ST_ONE: begin
        fin   = 1'b1;
        st_nx = ST_IDLE;
        case (op_e'(op_q))
          OP_PUSH: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_m1;
            mem_wdata = arg_q;
            sp_op     = SP_DEC1;
          end
          OP_CALL: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_m1;
            mem_wdata = link_q;
            sp_op     = SP_DEC1;
            pc_ld     = 1'b1;
          end
          OP_SDEALLOC: sp_op = SP_ADDN;
          default: ;
        endcase
      end
      ST_PUSH_RD: begin
        mem_en   = 1'b1;
        mem_addr = arg_q;
        st_nx    = ST_PUSH_WR;
      end
      ST_PUSH_WR: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_m1;
        mem_wdata = mem_rdata;
        sp_op     = SP_DEC1;
        fin       = 1'b1;
        st_nx     = ST_IDLE;
      end
      ST_SAL_SAVE: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_m1;
        mem_wdata = bp;
        sp_op     = SP_DEC1;
        st_nx     = ST_SAL_ANCH;
      end
      ST_SAL_ANCH: begin
        bp_op = BP_FROM_SP;
        sp_op = SP_SUBN;
        fin   = 1'b1;
        st_nx = ST_IDLE;
      end
      ST_RET_UNW: begin
        sp_op = SP_FROM_BP;
        st_nx = ST_RET_RDBP;
      end
      ST_RET_RDBP: begin
        mem_en = 1'b1;
        st_nx  = ST_RET_LDBP;
      end
      ST_RET_LDBP: begin
        bp_op = BP_LOAD;
        sp_op = SP_INC1;
        st_nx = ST_RET_RDPC;
      end
      ST_RET_RDPC: begin
        mem_en = 1'b1;
        st_nx  = ST_RET_LDPC;
      end
      ST_RET_LDPC: begin
        sp_op = SP_INC1;
        pc_ld = 1'b1;
        pc_nx = mem_rdata;
        fin   = 1'b1;
        st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      op_q     <= '0;
      imm_q    <= 1'b0;
      arg_q    <= '0;
      link_q   <= '0;
      done     <= 1'b0;
      pc_valid <= 1'b0;
      pc_value <= '0;
    end else begin
      st_q     <= st_nx;
      done     <= fin;
      pc_valid <= pc_ld;
      if (pc_ld) pc_value <= pc_nx;
      if (accept) begin
        op_q   <= cmd_op;
        imm_q  <= cmd_imm;
        arg_q  <= cmd_arg;
        link_q <= cmd_link;
      end
    end
  end

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a new program counter is only announced on completion
  p_pc_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_valid |-> done);

  // R2: a taken command makes the unit busy
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

  // R12: writes only on an enabled access
  p_we_has_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R12: no memory traffic while idle
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mem_en);

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
  import sfs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic          cmd_imm,
  input  logic [AW-1:0] cmd_arg,
  input  logic [AW-1:0] cmd_link,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic          pc_valid,
  output logic [AW-1:0] pc_value,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] bp,
  output logic          err_wrap
);

  sp_op_e        sp_op;
  bp_op_e        bp_op;
  logic [AW-1:0] amount;
  logic          accept;

  sfs_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_imm   (cmd_imm),
    .cmd_arg   (cmd_arg),
    .cmd_link  (cmd_link),
    .sp        (sp),
    .bp        (bp),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sp_op     (sp_op),
    .bp_op     (bp_op),
    .amount    (amount),
    .accept    (accept),
    .done      (done),
    .pc_valid  (pc_valid),
    .pc_value  (pc_value)
  );

  sfs_ptr_regs #(.AW(AW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_op    (sp_op),
    .bp_op    (bp_op),
    .amount   (amount),
    .load_val (mem_rdata),
    .clr_err  (accept),
    .sp       (sp),
    .bp       (bp),
    .err      (err_wrap)
  );

endmodule

// File: tb/stack_frame_seq_tb.sv
module stack_frame_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic [2:0] cmd_op;
  logic       cmd_imm;
  logic [7:0] cmd_arg;
  logic [7:0] cmd_link;
  logic       mem_en, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       done, pc_valid, err_wrap;
  logic [7:0] pc_value, sp, bp;

  logic [7:0] mem [256];
  int         mem_acc = 0;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk = ~clk;

  stack_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_imm(cmd_imm), .cmd_arg(cmd_arg), .cmd_link(cmd_link),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .pc_valid(pc_valid), .pc_value(pc_value),
    .sp(sp), .bp(bp), .err_wrap(err_wrap)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      mem_acc <= mem_acc + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic imm,
                         input logic [7:0] arg, input logic [7:0] link,
                         output int edges, output logic pv, output logic [7:0] pcv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_imm = imm; cmd_arg = arg; cmd_link = link;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    edges = 0;
    forever begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done || edges > 40) break;
    end
    pv  = pc_valid;
    pcv = pc_value;
  endtask

  task automatic t_reset();
    chk("R1 sp", sp, 8'hFF);
    chk("R1 bp", bp, 8'hFF);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 done/pc_valid/err", {done, pc_valid, err_wrap}, 0);
  endtask

  task automatic t_push_lit();
    int e; logic pv; logic [7:0] pc;
    run_cmd(3'd0, 1'b1, 8'h5A, 8'h00, e, pv, pc);
    chk("R3 latency", e, 1);
    chk("R3 sp", sp, 8'hFE);
    chk("R3 mem", mem[8'hFE], 8'h5A);
  endtask

  task automatic t_push_mem();
    int e; logic pv; logic [7:0] pc;
    mem[8'h10] = 8'hC3;
    run_cmd(3'd0, 1'b0, 8'h10, 8'h00, e, pv, pc);
    chk("R4 latency", e, 2);
    chk("R4 sp", sp, 8'hFD);
    chk("R4 mem", mem[8'hFD], 8'hC3);
  endtask

  task automatic t_call();
    int e; logic pv; logic [7:0] pc;
    run_cmd(3'd1, 1'b0, 8'h80, 8'h21, e, pv, pc);
    chk("R5 latency", e, 1);
    chk("R5 sp", sp, 8'hFC);
    chk("R5 mem", mem[8'hFC], 8'h21);
    chk("R5 pc_valid", pv, 1);
    chk("R5 pc", pc, 8'h80);
    @(negedge clk);
    chk("R9 done pulse", done, 0);
  endtask

  task automatic t_salloc();
    int e; logic pv; logic [7:0] pc;
    run_cmd(3'd2, 1'b0, 8'h04, 8'h00, e, pv, pc);
    chk("R6 latency", e, 2);
    chk("R6 mem", mem[8'hFB], 8'hFF);
    chk("R6 bp", bp, 8'hFB);
    chk("R6 sp", sp, 8'hF7);
    chk("R9 no pc_valid", pv, 0);
  endtask

  task automatic t_ret();
    int e; logic pv; logic [7:0] pc;
    run_cmd(3'd3, 1'b0, 8'h00, 8'h00, e, pv, pc);
    chk("R7 latency", e, 5);
    chk("R7 bp", bp, 8'hFF);
    chk("R7 sp", sp, 8'hFD);
    chk("R7 pc_valid", pv, 1);
    chk("R7 pc", pc, 8'h21);
    chk("R10 no wrap", err_wrap, 0);
  endtask

  task automatic t_sdealloc();
    int e; int a0; logic pv; logic [7:0] pc;
    a0 = mem_acc;
    run_cmd(3'd4, 1'b0, 8'h02, 8'h00, e, pv, pc);
    chk("R8 latency", e, 1);
    chk("R8 sp", sp, 8'hFF);
    chk("R8 bp", bp, 8'hFF);
    chk("R12 no access", mem_acc - a0, 0);
  endtask

  task automatic t_unused();
    int e; int a0; logic pv; logic [7:0] pc;
    for (int c = 5; c < 8; c++) begin
      a0 = mem_acc;
      run_cmd(c[2:0], 1'b1, 8'h33, 8'h44, e, pv, pc);
      chk("R11 latency", e, 1);
      chk("R11 sp/bp", {sp, bp}, 16'hFFFF);
      chk("R11 no pc_valid", pv, 0);
      chk("R11 no access", mem_acc - a0, 0);
    end
  endtask

  task automatic t_wrap();
    int e; logic pv; logic [7:0] pc;
    run_cmd(3'd4, 1'b0, 8'h01, 8'h00, e, pv, pc);
    chk("R10 sp up-wrap", sp, 8'h00);
    chk("R10 err up", err_wrap, 1);
    run_cmd(3'd0, 1'b1, 8'h9E, 8'h00, e, pv, pc);
    chk("R10 sp down-wrap", sp, 8'hFF);
    chk("R10 mem", mem[8'hFF], 8'h9E);
    chk("R10 err down", err_wrap, 1);
    run_cmd(3'd4, 1'b0, 8'h00, 8'h00, e, pv, pc);
    chk("R10 err cleared", err_wrap, 0);
    run_cmd(3'd2, 1'b0, 8'h05, 8'h00, e, pv, pc);
    chk("R6 sp", sp, 8'hF9);
    chk("R6 bp", bp, 8'hFE);
    chk("R10 salloc no wrap", err_wrap, 0);
    run_cmd(3'd3, 1'b0, 8'h00, 8'h00, e, pv, pc);
    chk("R7 pc at top", pc, 8'h9E);
    chk("R7 sp wrapped", sp, 8'h00);
    chk("R10 ret wrap", err_wrap, 1);
  endtask

  task automatic t_hold();
    bit saw_ready = 0;
    int e = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_imm = 1'b0; cmd_arg = 8'h02; cmd_link = 8'h00;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0; cmd_imm = 1'b1; cmd_arg = 8'h77;
    forever begin
      if (done) break;
      if (cmd_ready) saw_ready = 1;
      @(posedge clk); e++;
      @(negedge clk);
      if (e > 40) break;
    end
    chk("R2 busy not ready", saw_ready, 0);
    chk("R6 bp", bp, 8'hFF);
    chk("R6 sp", sp, 8'hFD);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 held push once sp", sp, 8'hFC);
    chk("R2 held push mem", mem[8'hFC], 8'h77);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem_rdata = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_imm = 1'b0;
    cmd_arg = 8'h00; cmd_link = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_lit();
    t_push_mem();
    t_call();
    t_salloc();
    t_ret();
    t_sdealloc();
    t_unused();
    t_wrap();
    t_hold();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule